// File: doc/BRIEF.md
# Power-Up Rail Sequencer

This block is the control state machine of a power-management unit. Once a backup supply is seen, it switches on an always-on regulator and holds the host processor in reset. It reports a battery fault until the main battery is good. It releases the host reset only after a minimum hold time, counted in clock cycles.

The host then drives the rest of the bring-up through an enable handshake. A rising edge on the system-enable input switches on the core high-voltage regulator first, which feeds the core, band-gap, oscillator and PLL domains. The remaining high-voltage rails follow either after a programmable gap or in the same cycle, depending on a delay-mode input. After that, a power-enable request turns on the low-voltage regulators. The request comes from a pin or from a register bit, and the two are ORed.

A power-OK status vector shows which rail groups are on. Losing the backup supply shuts everything down. Losing the main battery returns the block to its reset hold.

Top module: `pwr_seq`

## Requirements
- R1: While the backup supply is absent, every enable is low, `host_rst_n` is low and `pok` is zero. One cycle after `bkup_ok` is sampled high, `aon_en` is high while `host_rst_n` stays low.
- R2: `batt_flt_n` is high exactly when `bkup_ok` and `batt_good` were both high at the previous clock edge, and low otherwise.
- R3: `host_rst_n` rises exactly `RST_HOLD` cycles after the first of `RST_HOLD` consecutive edges that sample `bkup_ok` and `batt_good` both high while in the hold. It never rises sooner.
- R4: Once reset is released, a sampled rising edge of `sys_en` sets `hv1_en` one cycle later. A `sys_en` that is already high without a new edge starts nothing.
- R5: With `dly_mode` high at the `sys_en` edge, `hv_rest_en` stays zero for `RAIL_GAP` cycles after `hv1_en` rises, and then all of its bits go high together.
- R6: With `dly_mode` low at the `sys_en` edge, every bit of `hv_rest_en` rises in the same cycle as `hv1_en`.
- R7: Once every high-voltage rail is on, `lv_en` (all bits) is high one cycle after `pwr_en_pin | pwr_en_reg` is sampled high. It is low one cycle after both are sampled low.
- R8: A power-enable request is ignored while any high-voltage rail is still off, so `lv_en` stays zero.
- R9: A sampled low on `bkup_ok` clears every enable, `host_rst_n` and `batt_flt_n` one cycle later. A sampled low on `batt_good` after the hold clears the high- and low-voltage enables and `host_rst_n` one cycle later, keeps `aon_en` high, and restarts the hold.
- R10: `pok` bit 0 mirrors `aon_en`, bit 1 mirrors `hv1_en`, bit 2 is set when the rest of the high-voltage rails are on, and bit 3 is set when the low-voltage rails are on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bkup_ok | input | 1 | Backup supply present |
| batt_good | input | 1 | Main battery available |
| sys_en | input | 1 | Host system-enable, rising edge starts high-voltage bring-up |
| pwr_en_pin | input | 1 | Low-voltage enable request from pin |
| pwr_en_reg | input | 1 | Low-voltage enable request from register bit |
| dly_mode | input | 1 | Insert gap between core and remaining high-voltage rails |
| aon_en | output | 1 | Always-on regulator enable |
| host_rst_n | output | 1 | Active-low reset to host |
| batt_flt_n | output | 1 | Active-low battery-fault flag |
| hv1_en | output | 1 | Core high-voltage regulator enable |
| hv_rest_en | output | NUM_HV | Remaining high-voltage rail enables |
| lv_en | output | NUM_LV | Low-voltage regulator enables |
| pok | output | 4 | Power-OK per rail group |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between edges. They also assume that `RST_HOLD` and `RAIL_GAP` are at least one. The edge-based checks take the first sample after reset as the reference for `sys_en`. The stimulus changes inputs only on the falling clock edge and holds each level for whole cycles. It lowers `sys_en` before every new start, and it removes the battery and backup supply only at points where the expected collapse can be predicted.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int RST_HOLD = 5000000,
  parameter int RAIL_GAP = 1000,
  parameter int NUM_HV   = 3,
  parameter int NUM_LV   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bkup_ok,
  input  logic              batt_good,
  input  logic              sys_en,
  input  logic              pwr_en_pin,
  input  logic              pwr_en_reg,
  input  logic              dly_mode,
  output logic              aon_en,
  output logic              host_rst_n,
  output logic              batt_flt_n,
  output logic              hv1_en,
  output logic [NUM_HV-1:0] hv_rest_en,
  output logic [NUM_LV-1:0] lv_en,
  output logic [3:0]        pok
);
  localparam int MAXC = (RST_HOLD > RAIL_GAP) ? RST_HOLD : RAIL_GAP;
  localparam int CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] HOLD_END = CW'(RST_HOLD - 1);
  localparam logic [CW-1:0] GAP_END  = CW'(RAIL_GAP - 1);

  typedef enum logic [2:0] {S_OFF, S_HOLD, S_WAIT, S_HV1, S_HVALL, S_LV} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          sys_q, flt_q;
  wire           sys_rise = sys_en & ~sys_q;
  wire           lv_req   = pwr_en_pin | pwr_en_reg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_OFF;
      cnt   <= '0;
      sys_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      sys_q <= sys_en;
      flt_q <= bkup_ok & batt_good;
      if (!bkup_ok) begin
        st  <= S_OFF;
        cnt <= '0;
      end else if (st == S_OFF) begin
        st  <= S_HOLD;
        cnt <= '0;
      end else if (!batt_good) begin
        st  <= S_HOLD;
        cnt <= '0;
      end else begin
        unique case (st)
          S_HOLD:
            if (cnt == HOLD_END) begin
              st  <= S_WAIT;
              cnt <= '0;
            end else cnt <= cnt + 1'b1;
          S_WAIT:
            if (sys_rise) begin
              st  <= dly_mode ? S_HV1 : S_HVALL;
              cnt <= '0;
            end
          S_HV1:
            if (cnt == GAP_END) st <= S_HVALL;
            else cnt <= cnt + 1'b1;
          S_HVALL, S_LV: st <= lv_req ? S_LV : S_HVALL;
          default: st <= S_OFF;
        endcase
      end
    end
  end

  assign aon_en     = (st != S_OFF);
  assign host_rst_n = (st == S_WAIT) || (st == S_HV1) || (st == S_HVALL) || (st == S_LV);
  assign hv1_en     = (st == S_HV1) || (st == S_HVALL) || (st == S_LV);
  assign hv_rest_en = {NUM_HV{(st == S_HVALL) || (st == S_LV)}};
  assign lv_en      = {NUM_LV{st == S_LV}};
  assign batt_flt_n = flt_q;
  assign pok        = {lv_en[0], hv_rest_en[0], hv1_en, aon_en};

  logic [CW-1:0] good_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) good_run <= '0;
    else if (!(bkup_ok && batt_good)) good_run <= '0;
    else if (good_run < CW'(RST_HOLD)) good_run <= good_run + 1'b1;
  end

  assert_backup_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !bkup_ok |=> (!aon_en && !hv1_en && hv_rest_en == '0 && lv_en == '0 && !host_rst_n && !batt_flt_n));
  assert_flt_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bkup_ok && batt_good) |=> batt_flt_n);
  assert_flt_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bkup_ok && batt_good) |=> !batt_flt_n);
  assert_hold_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_rst_n) |-> (good_run >= CW'(RST_HOLD)));
  assert_start_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hv1_en) |-> ($past(sys_en) && host_rst_n));
  assert_core_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (hv_rest_en != '0) |-> hv1_en);
  assert_gap_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv1_en) && $past(dly_mode)) |-> (hv_rest_en == '0));
  assert_no_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hv1_en) && !$past(dly_mode)) |-> (&hv_rest_en));
  assert_lv_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_en != '0) |-> (hv1_en && (&hv_rest_en)));
  assert_pok_map_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pok == {(&lv_en), (&hv_rest_en), hv1_en, aon_en});
endmodule

// File: tb/test_pwr_seq.sv
module test_pwr_seq;
  localparam int HOLD = 8;
  localparam int GAP  = 3;
  localparam int NHV  = 3;
  localparam int NLV  = 2;

  logic clk = 0, rst_n = 0;
  logic bkup_ok = 0, batt_good = 0, sys_en = 0, pwr_en_pin = 0, pwr_en_reg = 0, dly_mode = 0;
  logic aon_en, host_rst_n, batt_flt_n, hv1_en;
  logic [NHV-1:0] hv_rest_en;
  logic [NLV-1:0] lv_en;
  logic [3:0] pok;

  pwr_seq #(.RST_HOLD(HOLD), .RAIL_GAP(GAP), .NUM_HV(NHV), .NUM_LV(NLV)) i_pwr_seq (
    .clk(clk), .rst_n(rst_n), .bkup_ok(bkup_ok), .batt_good(batt_good), .sys_en(sys_en),
    .pwr_en_pin(pwr_en_pin), .pwr_en_reg(pwr_en_reg), .dly_mode(dly_mode),
    .aon_en(aon_en), .host_rst_n(host_rst_n), .batt_flt_n(batt_flt_n), .hv1_en(hv1_en),
    .hv_rest_en(hv_rest_en), .lv_en(lv_en), .pok(pok));

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // reference model: phase 0 off, 1 hold, 2 released, 3 core rail, 4 all HV, 5 LV on
  int ph = 0, hc = 0, gc = 0;
  bit sprev = 0, mflt = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; hc = 0; gc = 0; sprev = 0; mflt = 0;
    end else begin
      bit rise;
      rise = sys_en && !sprev;
      sprev = sys_en;
      mflt = bkup_ok && batt_good;
      if (!bkup_ok) ph = 0;
      else if (ph == 0) begin ph = 1; hc = 0; end
      else if (!batt_good) begin ph = 1; hc = 0; end
      else if (ph == 1) begin
        hc++;
        if (hc == HOLD) ph = 2;
      end else if (ph == 2) begin
        if (rise) begin ph = dly_mode ? 3 : 4; gc = 0; end
      end else if (ph == 3) begin
        gc++;
        if (gc == GAP) ph = 4;
      end else ph = (pwr_en_pin || pwr_en_reg) ? 5 : 4;
    end
    #2;
    if (!done) begin
      chk(aon_en == (ph != 0), "R1 aon_en", aon_en, ph != 0);
      chk(host_rst_n == (ph >= 2), "R3 host_rst_n", host_rst_n, ph >= 2);
      chk(batt_flt_n == mflt, "R2 batt_flt_n", batt_flt_n, mflt);
      chk(hv1_en == (ph >= 3), "R4 hv1_en", hv1_en, ph >= 3);
      chk(hv_rest_en == (ph >= 4 ? {NHV{1'b1}} : '0), "R5 hv_rest_en", hv_rest_en, ph >= 4);
      chk(lv_en == (ph == 5 ? {NLV{1'b1}} : '0), "R7 lv_en", lv_en, ph == 5);
      chk(pok == {ph == 5, ph >= 4, ph >= 3, ph != 0}, "R10 pok", pok,
          {ph == 5, ph >= 4, ph >= 3, ph != 0});
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    step(2);
    rst_n = 1;
    step(1);
    chk(!aon_en && !host_rst_n && pok == 0, "R1 off state", pok, 0);
    bkup_ok = 1;
    step(1);
    chk(aon_en && !host_rst_n, "R1 aon on, reset held", host_rst_n, 0);
    step(11);
    chk(!host_rst_n && !batt_flt_n, "R3 hold without battery", host_rst_n, 0);
    batt_good = 1;
    step(1);
    chk(batt_flt_n, "R2 fault cleared", batt_flt_n, 1);
    pwr_en_pin = 1;
    step(HOLD - 2);
    chk(!host_rst_n, "R3 not yet released", host_rst_n, 0);
    step(1);
    chk(host_rst_n, "R3 released", host_rst_n, 1);
    step(4);
    chk(lv_en == 0, "R8 request ignored", lv_en, 0);
    pwr_en_pin = 0;
    dly_mode = 1;
    sys_en = 1;
    step(1);
    chk(hv1_en && hv_rest_en == 0, "R5 core first", hv_rest_en, 0);
    step(GAP - 1);
    chk(hv_rest_en == 0, "R5 gap holds", hv_rest_en, 0);
    step(1);
    chk(&hv_rest_en, "R5 rest on", hv_rest_en, 7);
    pwr_en_reg = 1;
    step(1);
    chk(&lv_en && pok == 4'hF, "R7 reg request", lv_en, 3);
    pwr_en_reg = 0;
    step(1);
    chk(lv_en == 0, "R7 request dropped", lv_en, 0);
    pwr_en_pin = 1;
    step(1);
    chk(&lv_en, "R7 pin request", lv_en, 3);
    batt_good = 0;
    step(1);
    chk(aon_en && !host_rst_n && !hv1_en && lv_en == 0 && pok == 4'h1, "R9 battery loss", pok, 1);
    batt_good = 1;
    step(HOLD + 3);
    chk(host_rst_n && !hv1_en, "R4 level sys_en ignored", hv1_en, 0);
    pwr_en_pin = 0;
    sys_en = 0;
    dly_mode = 0;
    step(2);
    sys_en = 1;
    step(1);
    chk(hv1_en && (&hv_rest_en), "R6 all HV together", hv_rest_en, 7);
    pwr_en_pin = 1;
    step(2);
    bkup_ok = 0;
    step(1);
    chk(!aon_en && !host_rst_n && !batt_flt_n && pok == 0, "R9 backup loss", pok, 0);
    step(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    fails++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule